// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands, a multiplicand of `A_W` bits and a multiplier of `B_W` bits (32 and 32 by default), into an exact `A_W+B_W`-bit product. It uses a single `A_W`-bit adder and one product register. The product register's low half starts out holding the multiplier and is used up one bit per iteration. Each iteration takes one clock. If the register's bit 0 is set, the multiplicand is added into the upper half. The whole register then moves right by one place, and the adder's carry-out enters at the top bit.

Operands arrive on a valid/ready interface. A request transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for as long as a multiply is running, so a source that holds `in_valid` high is simply stalled; nothing is queued or dropped silently. The result has no back-pressure. `done` pulses for one cycle when `product` is final, and `product` then stays unchanged until the next request is accepted. A new request can be accepted in the same cycle that `done` is high, so multiplies can run back to back with no idle cycle between them.

Top module: `seq_shift_mul`

## Requirements
- R1: A synchronous reset, taken at any time including mid-operation, leaves `busy` = 0, `done` = 0, `in_ready` = 1 and `product` = 0; an operation in progress is abandoned.
- R2: A request is accepted only on an edge with `in_valid` = 1 and `in_ready` = 1; `in_ready` is 0 while `busy` is 1, and operands presented while busy have no effect on the running product.
- R3: In the cycle after acceptance, `product` shows the upper `A_W` bits cleared and the lower `B_W` bits equal to the accepted multiplier.
- R4: The final `product` equals the full unsigned product of the accepted operands with no bit lost, including all-ones times all-ones, so the carry-out of each add must reach the top bit.
- R5: Exactly `B_W` iteration clocks follow the accept edge; if the request is accepted on edge k, `done` is high during the cycle following edge k+`B_W`.
- R6: `done` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R7: While idle and no request is accepted, `product` holds its last value.
- R8: A request presented during the `done` cycle is accepted on the next edge, which is `B_W`+1 edges after the previous accept.
- R9: A zero multiplicand or a zero multiplier gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can accept an operand pair (high when idle) |
| in_mcand | input | A_W | Multiplicand |
| in_mplier | input | B_W | Multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: `product` is final |
| product | output | A_W+B_W | Product register |

## Verification
The embedded properties watch, on every cycle, the load image of the product register, that an active multiply cannot be disturbed by a new request, the iteration count between accept and `done`, the single-cycle width of `done`, that an idle result is held, and that the final value equals the true product of the captured operands. Some behaviours depend on stimulus sequences and can only be shown by the bench's scenarios. These are: reset striking mid-operation, operands offered while busy being truly discarded, back-to-back issue timing at the `done` cycle, and the arithmetic of specific corner pairs (all-ones, zero, single high bit) compared against a scoreboard.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    SM_IDLE = 1'b0,
    SM_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(ITER - 1);

  smul_state_e state_q;
  logic [CW-1:0] iter_q;
  logic          done_q;
  logic          final_step;

  assign busy       = (state_q == SM_RUN);
  assign in_ready   = !busy;
  assign load       = in_ready && in_valid;
  assign step       = busy;
  assign final_step = busy && (iter_q == LAST_IDX);
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SM_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SM_IDLE: begin
          if (in_valid) begin
            state_q <= SM_RUN;
            iter_q  <= '0;
          end
        end
        SM_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (final_step) begin
            state_q <= SM_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= SM_IDLE;
      endcase
    end
  end

  // R6: done never lasts longer than one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: done only follows a running multiply and comes with busy low
  assert_done_after_run_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R2: a request offered mid-run does not restart or end the run
  assert_busy_ignores_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && in_valid && !final_step) |=> (busy && iter_q == $past(iter_q) + 1'b1));
endmodule

// File: rtl/smul_adder.sv
module smul_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  logic         enable,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [W-1:0] gated;

  assign gated        = enable ? addend : '0;
  assign {carry, sum} = {1'b0, acc} + {1'b0, gated};
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int A_W = 32,
  parameter int B_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [A_W-1:0]     a_in,
  input  logic [B_W-1:0]     b_in,
  output logic [A_W+B_W-1:0] prod
);
  localparam int P_W = A_W + B_W;

  logic [A_W-1:0] mcand_q;
  logic [P_W-1:0] prod_q;
  logic [A_W-1:0] upper_sum;
  logic           upper_carry;

  smul_adder #(.W(A_W)) u_add (
    .acc    (prod_q[P_W-1:B_W]),
    .addend (mcand_q),
    .enable (prod_q[0]),
    .sum    (upper_sum),
    .carry  (upper_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= a_in;
      prod_q  <= {{A_W{1'b0}}, b_in};
    end else if (step) begin
      prod_q <= {upper_carry, upper_sum, prod_q[B_W-1:1]};
    end
  end

  assign prod = prod_q;

  // R3: load image is zero upper half over the multiplier
  assert_load_image_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (prod == {{A_W{1'b0}}, $past(b_in)}));

  // R4: multiplicand is untouched while iterating
  assert_mcand_held_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> $stable(mcand_q));

  // R7: idle register holds its value
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(prod_q));
endmodule

// File: rtl/seq_shift_mul.sv
module seq_shift_mul #(
  parameter int A_W = 32,
  parameter int B_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [A_W-1:0]     in_mcand,
  input  logic [B_W-1:0]     in_mplier,
  output logic               busy,
  output logic               done,
  output logic [A_W+B_W-1:0] product
);
  localparam int P_W = A_W + B_W;
  localparam int KW  = $clog2(B_W + 2);

  logic load, step;

  smul_ctrl #(.ITER(B_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load     (load),
    .step     (step),
    .busy     (busy),
    .done     (done)
  );

  smul_datapath #(.A_W(A_W), .B_W(B_W)) u_dp (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .step (step),
    .a_in (in_mcand),
    .b_in (in_mplier),
    .prod (product)
  );

  // Checker state: captured operands and iteration clocks since accept
  logic [A_W-1:0] chk_a;
  logic [B_W-1:0] chk_b;
  logic [KW-1:0]  chk_clks;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_a    <= '0;
      chk_b    <= '0;
      chk_clks <= '0;
    end else if (in_valid && in_ready) begin
      chk_a    <= in_mcand;
      chk_b    <= in_mplier;
      chk_clks <= '0;
    end else if (busy) begin
      chk_clks <= chk_clks + 1'b1;
    end
  end

  // R5: done arrives after exactly B_W iteration clocks
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (chk_clks == KW'(B_W)));

  // R4: final value is the exact full-width product
  assert_exact_product_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == P_W'(chk_a) * P_W'(chk_b)));

  // R2: ready is withheld for the whole run
  assert_ready_low_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);
endmodule

// File: tb/test_seq_shift_mul.sv
module test_seq_shift_mul;
  localparam int A_W = 32;
  localparam int B_W = 32;
  localparam int P_W = A_W + B_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [A_W-1:0] in_mcand = '0;
  logic [B_W-1:0] in_mplier = '0;
  logic busy, done;
  logic [P_W-1:0] product;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic [P_W-1:0] exp_q[$];
  int             acc_q[$];
  logic [P_W-1:0] last_result = '0;
  logic           prev_done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seq_shift_mul #(.A_W(A_W), .B_W(B_W)) i_seq_shift_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mcand(in_mcand), .in_mplier(in_mplier), .busy(busy),
    .done(done), .product(product)
  );

  task automatic chk(input bit ok, input string req, input logic [P_W-1:0] act,
                     input logic [P_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [A_W-1:0] a, input logic [B_W-1:0] b, output int acc);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_mcand  = a;
    in_mplier = b;
    exp_q.push_back(P_W'(a) * P_W'(b));
    @(posedge clk);
    #1;
    acc = cyc;
    acc_q.push_back(cyc);
    in_valid = 1'b0;
    @(negedge clk);
    chk(product == {{A_W{1'b0}}, b}, "R3 load image", product, {{A_W{1'b0}}, b});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) chk(done == 1'b0, "R6 done width", P_W'(done), '0);
      prev_done = done;
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected done", product, '0);
        end else begin
          logic [P_W-1:0] e;
          int a;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          chk(product == e, "R4 product", product, e);
          chk(cyc == a + B_W, "R5 latency", P_W'(cyc), P_W'(a + B_W));
          chk(busy == 1'b0, "R6 busy with done", P_W'(busy), '0);
          last_result = product;
        end
      end
    end
  end

  initial begin
    int acc1, acc2, tmp;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && in_ready == 1 && product == '0,
        "R1 reset state", product, '0);
    rst = 1'b0;

    // Corner cases
    issue('1, '1, tmp);
    issue(32'h0000_0001, 32'hDEAD_BEEF, tmp);
    issue(32'h8000_0000, 32'h0000_0002, tmp);
    issue(32'hAAAA_AAAA, 32'h5555_5555, tmp);
    issue(32'd5, 32'd11, tmp);
    drain();

    // R9 zero operands
    issue('0, 32'h1234_5678, tmp);
    drain();
    chk(product == '0, "R9 zero multiplicand", product, '0);
    issue(32'hFFFF_0001, '0, tmp);
    drain();
    chk(product == '0, "R9 zero multiplier", product, '0);

    // R8 back to back
    issue(32'h0001_0001, 32'h0000_FFFF, acc1);
    issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, acc2);
    chk(acc2 == acc1 + B_W + 1, "R8 back-to-back accept", P_W'(acc2), P_W'(acc1 + B_W + 1));
    drain();

    // R2 requests while busy are ignored
    issue(32'h0000_0003, 32'h0000_0007, tmp);
    for (int i = 0; i < 5; i++) begin
      in_valid  = 1'b1;
      in_mcand  = 32'hFFFF_FFFF;
      in_mplier = 32'h1111_1111;
      @(negedge clk);
      chk(in_ready == 1'b0 && busy == 1'b1, "R2 ready low while busy", P_W'(in_ready), '0);
    end
    in_valid = 1'b0;
    drain();
    chk(product == P_W'(21), "R2 busy request ignored", product, P_W'(21));

    // R7 hold while idle
    repeat (6) @(negedge clk);
    chk(product == last_result, "R7 idle hold", product, last_result);

    // R1 reset mid-run
    issue(32'h1357_9BDF, 32'h2468_ACE0, tmp);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    acc_q.delete();
    @(negedge clk);
    chk(busy == 0 && done == 0 && in_ready == 1 && product == '0,
        "R1 reset mid-run", product, '0);
    rst = 1'b0;
    prev_done = 1'b0;

    // Random operands
    for (int k = 0; k < 20; k++) begin
      issue($urandom, $urandom, tmp);
    end
    drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule